// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block is a synchronous sequencer that runs one port of an external asynchronous static RAM. The RAM has 4096 byte-wide locations. Its chip enable, output enable and write strobe are all active low. On the user side the block takes a one-cycle request made of an address, write data and a write flag. It holds `ready` low while the memory cycle and its recovery are in progress. For a read it returns the sampled byte together with a one-cycle valid pulse.

Every minimum memory timing is a parameter counted in whole clock cycles, with each nanosecond figure rounded up. The rules for a write strobe are set by the memory: the strobe is the overlap of chip enable low and write strobe low, and whichever edge rises first ends the write. The block builds its writes in one of two ways, chosen by a parameter. In the first, the write strobe falls before chip enable, so the memory's outputs never turn on. In the second, chip enable frames the cycle and the write strobe forms the pulse, and output enable may stay low. In that case the pulse is lengthened so the memory releases the bus before the block drives data. When the block is idle, chip enable is high and the memory sits in standby.

The data bus is split into an output value, an output-enable and an input value. An I/O pad outside the block joins them into the bidirectional pins.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is high and just after it is released, `ready`=1, `sram_ce_n`=`sram_oe_n`=`sram_we_n`=1, `sram_dq_oe`=0 and `rd_valid`=0.
- R2: Whenever `ready` is 1, `sram_ce_n`=1, `sram_we_n`=1 and `sram_dq_oe`=0, which is standby with the bus released.
- R3: While `sram_ce_n` and `sram_we_n` are both 0, `sram_addr` does not change.
- R4: A read samples `sram_dq_i` after output enable has been low for ACC=max(T_AA,T_ACE,T_AOE) cycles, with a minimum of 1. `rd_valid` is a single-cycle pulse, visible 1+ACC clock edges after the edge that accepted the request. `rd_data` holds the sampled byte.
- R5: On a read, `sram_dq_oe` is 0 in the cycle before `sram_oe_n` falls.
- R6: With CE_CTRL=1, `sram_we_n` falls one cycle before `sram_ce_n` and `sram_oe_n` stays high. `sram_ce_n` is low for max(T_WP,T_DW) cycles, and `ready` returns 1+max(T_WP,T_DW)+T_DH+T_REC edges after acceptance.
- R7: With CE_CTRL=0 and OE_IN_WRITE=1, `sram_oe_n` stays low through the write strobe. The strobe lasts max(T_WP,T_WZ+T_DW) cycles, and the data driver stays off for its first T_WZ cycles. `ready` returns 1+max(T_WP,T_WZ+T_DW)+T_DH+T_REC edges after acceptance.
- R8: Write data is driven and stable for at least T_DW cycles before the strobe ends. When T_DH>0, it stays driven and unchanged in the cycle after the strobe ends.
- R9: The block never drives `sram_dq_oe`=1 in a cycle where the memory is driving its outputs.
- R10: A request is taken only while `ready`=1. `ready` is 0 in the cycle after acceptance, and a request raised while `ready`=0 has no effect on memory contents.
- R11: A read returns the byte most recently written to that address, including the addresses 0 and 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| ready | output | 1 | Idle and able to accept a request |
| rd_valid | output | 1 | One-cycle pulse when read data is returned |
| rd_data | output | DW | Returned read byte |
| sram_addr | output | AW | Memory address |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dq_o | output | DW | Data driven toward the memory |
| sram_dq_oe | output | DW == 0 ? 1 : 1 | Data driver enable |
| sram_dq_i | input | DW | Data returned by the memory |

## Verification
A sequencer stuck in the wrong state or holding a count off by one shows at the ports in the same operation. It appears as a `ready` return or `rd_valid` pulse one or more edges away from the computed cycle. It can also appear as a byte sampled before the memory model has finished its access delay. A wrong strobe decode shows within the strobe itself. The memory model flags, in the same cycle, any bus fight, any short pulse or setup window, any missing hold and any address that moves during a write. A lost write shows on the first readback of that address.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_TURN,
    ST_RD_WAIT,
    ST_WR_LEAD,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RECOVER
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned at_least1(input int unsigned a);
    return (a == 0) ? 1 : a;
  endfunction

endpackage

// File: rtl/sram_timer.sv
module sram_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW          = 3,
  parameter int unsigned ACC_C       = 5,
  parameter int unsigned TURN_C      = 3,
  parameter int unsigned PULSE_C     = 3,
  parameter int unsigned T_DH        = 1,
  parameter int unsigned T_REC       = 1,
  parameter bit          CE_CTRL     = 1'b0,
  parameter bit          OE_IN_WRITE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_zero,
  output logic          accept,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          capture,
  output logic          ready,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe
);

  seq_state_e st_q, st_d;
  logic       finish_op;
  logic       ce_d, oe_d, we_d, dqoe_d, rdy_d;

  // counter preload for a phase lasting n cycles (n >= 1)
  function automatic logic [CW-1:0] span(input int unsigned n);
    return CW'(n - 1);
  endfunction

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    capture   = 1'b0;
    finish_op = 1'b0;
    accept    = (st_q == ST_IDLE) && req_valid;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) st_d = req_write ? ST_WR_LEAD : ST_RD_TURN;
      end
      ST_RD_TURN: begin
        st_d     = ST_RD_WAIT;
        tmr_load = 1'b1;
        tmr_val  = span(ACC_C);
      end
      ST_RD_WAIT: begin
        if (tmr_zero) begin
          capture   = 1'b1;
          finish_op = 1'b1;
        end
      end
      ST_WR_LEAD: begin
        tmr_load = 1'b1;
        if (TURN_C != 0) begin
          st_d    = ST_WR_TURN;
          tmr_val = span(TURN_C);
        end else begin
          st_d    = ST_WR_PULSE;
          tmr_val = span(PULSE_C);
        end
      end
      ST_WR_TURN: begin
        if (tmr_zero) begin
          st_d     = ST_WR_PULSE;
          tmr_load = 1'b1;
          tmr_val  = span(PULSE_C);
        end
      end
      ST_WR_PULSE: begin
        if (tmr_zero) begin
          if (T_DH != 0) begin
            st_d     = ST_WR_HOLD;
            tmr_load = 1'b1;
            tmr_val  = span(T_DH);
          end else begin
            finish_op = 1'b1;
          end
        end
      end
      ST_WR_HOLD: begin
        if (tmr_zero) finish_op = 1'b1;
      end
      ST_RECOVER: begin
        if (tmr_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (finish_op) begin
      if (T_REC != 0) begin
        st_d     = ST_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = span(T_REC);
      end else begin
        st_d = ST_IDLE;
      end
    end
  end

  // pin levels for the state being entered, registered below
  always_comb begin
    ce_d   = 1'b1;
    oe_d   = 1'b1;
    we_d   = 1'b1;
    dqoe_d = 1'b0;
    rdy_d  = 1'b0;
    unique case (st_d)
      ST_IDLE:    rdy_d = 1'b1;
      ST_RD_TURN: ce_d  = 1'b0;
      ST_RD_WAIT: begin
        ce_d = 1'b0;
        oe_d = 1'b0;
      end
      ST_WR_LEAD: begin
        if (CE_CTRL) begin
          we_d = 1'b0;
        end else begin
          ce_d = 1'b0;
          oe_d = !OE_IN_WRITE;
        end
        dqoe_d = CE_CTRL || !OE_IN_WRITE;
      end
      ST_WR_TURN: begin
        ce_d = 1'b0;
        we_d = 1'b0;
        oe_d = !OE_IN_WRITE;
      end
      ST_WR_PULSE: begin
        ce_d   = 1'b0;
        we_d   = 1'b0;
        dqoe_d = 1'b1;
        if (!CE_CTRL) oe_d = !OE_IN_WRITE;
      end
      ST_WR_HOLD: begin
        dqoe_d = 1'b1;
        if (CE_CTRL) we_d = 1'b0;
        else         ce_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      ready <= 1'b1;
    end else begin
      st_q  <= st_d;
      ce_n  <= ce_d;
      oe_n  <= oe_d;
      we_n  <= we_d;
      dq_oe <= dqoe_d;
      ready <= rdy_d;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] din,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= din;
    end
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW          = 12,
  parameter int unsigned DW          = 8,
  parameter int unsigned T_WP        = 4,
  parameter int unsigned T_DW        = 3,
  parameter int unsigned T_DH        = 1,
  parameter int unsigned T_WZ        = 3,
  parameter int unsigned T_AA        = 5,
  parameter int unsigned T_ACE       = 5,
  parameter int unsigned T_AOE       = 3,
  parameter int unsigned T_REC       = 1,
  parameter bit          CE_CTRL     = 1'b0,
  parameter bit          OE_IN_WRITE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_i
);

  localparam int unsigned ACC_C   = at_least1(max2(T_AA, max2(T_ACE, T_AOE)));
  localparam int unsigned TURN_C  = (!CE_CTRL && OE_IN_WRITE) ? T_WZ : 0;
  localparam int unsigned REST_C  = (T_WP > TURN_C) ? (T_WP - TURN_C) : 0;
  localparam int unsigned PULSE_C = at_least1(max2(REST_C, T_DW));
  localparam int unsigned CNT_MAX = max2(max2(ACC_C, PULSE_C), max2(max2(TURN_C, T_DH), T_REC));
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  logic          accept, tmr_load, tmr_zero, capture;
  logic [CW-1:0] tmr_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  sram_seq #(
    .CW(CW), .ACC_C(ACC_C), .TURN_C(TURN_C), .PULSE_C(PULSE_C),
    .T_DH(T_DH), .T_REC(T_REC), .CE_CTRL(CE_CTRL), .OE_IN_WRITE(OE_IN_WRITE)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .tmr_zero(tmr_zero), .accept(accept), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .capture(capture), .ready(ready), .ce_n(sram_ce_n), .oe_n(sram_oe_n),
    .we_n(sram_we_n), .dq_oe(sram_dq_oe)
  );

  sram_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .capture(capture), .din(sram_dq_i),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // address and write data are frozen for the whole memory cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign sram_addr = addr_q;
  assign sram_dq_o = wdata_q;

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          ready,
  input logic          rd_valid,
  input logic [AW-1:0] sram_addr,
  input logic          sram_ce_n,
  input logic          sram_oe_n,
  input logic          sram_we_n,
  input logic          sram_dq_oe
);

  // R2: idle means standby with the bus released
  p_idle_standby_r2: assert property (@(posedge clk) disable iff (rst)
    ready |-> (sram_ce_n && sram_we_n && !sram_dq_oe));

  // R3: address frozen while the write strobe is active
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !sram_we_n) |=> ((sram_ce_n || sram_we_n) || $stable(sram_addr)));

  // R4: read data returned only after an output-enabled read cycle
  p_rdv_after_oe_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!sram_oe_n && sram_we_n));

  // R4: valid is a single-cycle pulse
  p_rdv_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R5: driver already off the cycle before output enable falls
  p_turnaround_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_oe_n) |-> $past(!sram_dq_oe));

  // R6: chip enable never opens a write before the write strobe is low
  p_ce_after_we_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(sram_ce_n) && !sram_we_n) |-> $past(!sram_we_n));

  // R9: no driving while the memory may be reading out
  p_no_fight_r9: assert property (@(posedge clk) disable iff (rst)
    (!sram_oe_n && sram_we_n) |-> !sram_dq_oe);

  // R10: accepted request makes the block busy at once
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready) |=> !ready);

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready), .rd_valid(rd_valid),
  .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
  .sram_we_n(sram_we_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/sram_port_ctrl_bench.sv
`timescale 1ns/1ps

// Cycle-level model of the asynchronous memory with protocol counters.
module sram_async_model #(
  parameter int AW = 12, parameter int DW = 8, parameter int ACC = 5,
  parameter int T_WP = 4, parameter int T_DW = 3, parameter int T_DH = 1, parameter int T_WZ = 3
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] dq_o,
  input  logic          dq_oe,
  output logic [DW-1:0] dq_i,
  output int            viol
);
  logic [DW-1:0] mem [1<<AW];
  int acc, wz_left, plen, dcnt;
  logic wr_prev;
  logic [DW-1:0] wdat;
  logic [AW-1:0] waddr;
  logic wr_now, mem_drv;

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    viol = 0; acc = 0; wz_left = 0; plen = 0; dcnt = 0; wr_prev = 0; wdat = '0; waddr = '0;
  end

  assign wr_now  = !ce_n && !we_n;
  assign mem_drv = !ce_n && !oe_n && (we_n || wz_left > 0);
  assign dq_i    = (acc >= ACC && !ce_n && !oe_n && we_n) ? mem[addr] : 8'hEE;

  always @(negedge clk) begin
    if (mem_drv && dq_oe) viol++;                       // R9
    if (!ce_n && !oe_n && we_n) begin
      if (acc < 1000) acc++;
      wz_left = T_WZ;
    end else begin
      acc = 0;
      if (!we_n && !ce_n && !oe_n && wz_left > 0) wz_left--;
      else wz_left = 0;
    end
    if (wr_now) begin
      if (wr_prev && addr != waddr) viol++;             // R3
      waddr = addr;
      plen++;
      if (dq_oe) begin
        if (dcnt > 0 && dq_o != wdat) dcnt = 1; else dcnt++;
        wdat = dq_o;
      end else dcnt = 0;
    end else if (wr_prev) begin
      if (plen < T_WP || dcnt < T_DW) viol++;           // R8 setup and width
      if (T_DH > 0 && !(dq_oe && dq_o == wdat)) viol++; // R8 hold
      mem[waddr] = wdat;
      plen = 0; dcnt = 0;
    end
    wr_prev = wr_now;
  end
endmodule

module sram_port_ctrl_bench;
  localparam int T_WP = 4, T_DW = 3, T_DH = 1, T_WZ = 3, T_AA = 5, T_ACE = 5, T_AOE = 3, T_REC = 1;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ACC     = imax(T_AA, imax(T_ACE, T_AOE));
  localparam int RLAT    = 1 + ACC;
  localparam int BUSY_WE = 1 + imax(T_WP, T_WZ + T_DW) + T_DH + T_REC;
  localparam int BUSY_CE = 1 + imax(T_WP, T_DW) + T_DH + T_REC;
  localparam int RBUSY   = 1 + ACC + T_REC;

  logic clk = 0;
  logic rst = 1;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [7:0]  req_wdata = 0;

  logic rdy_a, rdv_a, ce_a, oe_a, we_a, dqoe_a;
  logic rdy_b, rdv_b, ce_b, oe_b, we_b, dqoe_b;
  logic [7:0] rdd_a, dqo_a, dqi_a, rdd_b, dqo_b, dqi_b;
  logic [11:0] addr_a, addr_b;
  int viol_a, viol_b;

  int errors = 0, checks = 0;
  bit reported = 0;
  logic [7:0] exp_mem [4096];

  sram_port_ctrl #(.T_WP(T_WP), .T_DW(T_DW), .T_DH(T_DH), .T_WZ(T_WZ), .T_AA(T_AA),
    .T_ACE(T_ACE), .T_AOE(T_AOE), .T_REC(T_REC), .CE_CTRL(1'b0), .OE_IN_WRITE(1'b1))
  u_sram_port_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(rdy_a), .rd_valid(rdv_a), .rd_data(rdd_a), .sram_addr(addr_a),
    .sram_ce_n(ce_a), .sram_oe_n(oe_a), .sram_we_n(we_a), .sram_dq_o(dqo_a),
    .sram_dq_oe(dqoe_a), .sram_dq_i(dqi_a));

  sram_port_ctrl #(.T_WP(T_WP), .T_DW(T_DW), .T_DH(T_DH), .T_WZ(T_WZ), .T_AA(T_AA),
    .T_ACE(T_ACE), .T_AOE(T_AOE), .T_REC(T_REC), .CE_CTRL(1'b1), .OE_IN_WRITE(1'b0))
  u_sram_port_ctrl_ce (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(rdy_b), .rd_valid(rdv_b), .rd_data(rdd_b), .sram_addr(addr_b),
    .sram_ce_n(ce_b), .sram_oe_n(oe_b), .sram_we_n(we_b), .sram_dq_o(dqo_b),
    .sram_dq_oe(dqoe_b), .sram_dq_i(dqi_b));

  sram_async_model #(.ACC(ACC), .T_WP(T_WP), .T_DW(T_DW), .T_DH(T_DH), .T_WZ(T_WZ)) m_a (
    .clk(clk), .addr(addr_a), .ce_n(ce_a), .oe_n(oe_a), .we_n(we_a), .dq_o(dqo_a),
    .dq_oe(dqoe_a), .dq_i(dqi_a), .viol(viol_a));
  sram_async_model #(.ACC(ACC), .T_WP(T_WP), .T_DW(T_DW), .T_DH(T_DH), .T_WZ(T_WZ)) m_b (
    .clk(clk), .addr(addr_b), .ce_n(ce_b), .oe_n(oe_b), .we_n(we_b), .dq_o(dqo_b),
    .dq_oe(dqoe_b), .dq_i(dqi_b), .viol(viol_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // one request on both instances; measures busy time and read return
  task automatic issue(input logic w, input logic [11:0] a, input logic [7:0] d, input bit inj,
                       output int busy_a, output int busy_b, output int rl_a, output int rl_b,
                       output logic [7:0] rv_a, output logic [7:0] rv_b);
    int n;
    busy_a = -1; busy_b = -1; rl_a = -1; rl_b = -1; rv_a = 0; rv_b = 0;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    n = 0;
    req_valid = 0;
    if (inj) begin
      chk(!rdy_a && !rdy_b, "R10 ready low after accept", int'(rdy_a), 0);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = ~d;
    end
    while (busy_a < 0 || busy_b < 0) begin
      if (rdv_a && rl_a < 0) begin rl_a = n; rv_a = rdd_a; end
      if (rdv_b && rl_b < 0) begin rl_b = n; rv_b = rdd_b; end
      @(posedge clk);
      n++;
      @(negedge clk);
      req_valid = 0;
      if (rdy_a && busy_a < 0) busy_a = n;
      if (rdy_b && busy_b < 0) busy_b = n;
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d, input bit inj);
    int ba, bb, la, lb;
    logic [7:0] va, vb;
    issue(1'b1, a, d, inj, ba, bb, la, lb, va, vb);
    exp_mem[a] = d;
    chk(ba == BUSY_WE, "R7 write busy, strobe-controlled with output enable low", ba, BUSY_WE);
    chk(bb == BUSY_CE, "R6 write busy, chip-enable-controlled", bb, BUSY_CE);
    chk(ce_a && we_a && !dqoe_a && ce_b && we_b && !dqoe_b, "R2 standby when idle",
        int'({ce_a, we_a, dqoe_a}), 6);
  endtask

  task automatic do_read(input logic [11:0] a);
    int ba, bb, la, lb;
    logic [7:0] va, vb;
    issue(1'b0, a, 8'h00, 1'b0, ba, bb, la, lb, va, vb);
    chk(la == RLAT && lb == RLAT, "R4 read return cycle", la, RLAT);
    chk(ba == RBUSY && bb == RBUSY, "R4 read busy", ba, RBUSY);
    chk(va == exp_mem[a], "R11 readback data (strobe-controlled)", int'(va), int'(exp_mem[a]));
    chk(vb == exp_mem[a], "R11 readback data (chip-enable-controlled)", int'(vb), int'(exp_mem[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    int seed;
    logic [11:0] addrs [40];
    for (int i = 0; i < 4096; i++) exp_mem[i] = 8'h00;
    seed = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rdy_a && rdy_b && ce_a && oe_a && we_a && !dqoe_a && !rdv_a &&
        ce_b && oe_b && we_b && !dqoe_b && !rdv_b, "R1 reset levels", int'(rdy_a), 1);
    rst = 0;
    @(negedge clk);
    chk(rdy_a && ce_a && oe_a && we_a && !dqoe_a && rdy_b && !rdv_b, "R1 levels after release",
        int'(ce_a), 1);

    // directed corners: lowest and highest address
    do_write(12'h000, 8'hA5, 1'b0);
    do_write(12'hFFF, 8'h3C, 1'b0);
    do_read(12'h000);
    do_read(12'hFFF);
    do_read(12'h123);          // never written, returns zero
    // R10 request during busy is dropped
    do_write(12'h010, 8'h11, 1'b1);
    do_read(12'h010);

    // constrained random traffic
    for (int i = 0; i < 40; i++) begin
      addrs[i] = 12'($urandom());
      do_write(addrs[i], 8'($urandom()), 1'b0);
      if ($urandom() % 3 == 0) do_read(addrs[($urandom() % (i + 1))]);
    end
    for (int i = 0; i < 40; i++) do_read(addrs[i]);

    chk(viol_a == 0, "R8 R9 R3 memory protocol (strobe-controlled)", viol_a, 0);
    chk(viol_b == 0, "R8 R9 R3 memory protocol (chip-enable-controlled)", viol_b, 0);
    report();
    $finish;
  end
endmodule